// File: doc/BRIEF.md
# Nonvolatile SRAM Store Protection Controller

This controller sits between the pins of a battery-free nonvolatile SRAM and its storage array. It decides, cycle by cycle, whether a write may reach the array. It also decides when a copy of the array into nonvolatile cells (a STORE) may begin. Two digital comparator flags report whether the main supply or the backup capacitor has dropped below the switch threshold. While either flag is set, externally requested writes and STOREs are refused.

A STORE can start in three ways: from a software request, from an external agent pulling the shared open-drain busy line low, or automatically when the main supply falls through the threshold. Automatic starts can be switched off by an inhibit input. Every STORE drives the busy line low for a fixed 20 microsecond window, measured by a cycle counter derived from the clock frequency. A short way into that window the line is read back through a two-flop synchronizer. If an outside driver is holding the line high, the STORE is abandoned and the status output reports the abort.

After reset, after a recall and after each completed STORE, a write with chip enable and write enable already low is not granted. The write is granted only once a fresh falling edge on either enable has been seen.

Top module: `nvStoreGuard`

## Requirements
- R1: During reset, wrGrant, storeStart and busyPullDown are 0 and storeStatus is 0 (idle).
- R2: wrGrant is 0 in every cycle in which vccLow or capLow is 1, whatever the state of the enables.
- R3: After reset, with ceN and weN both held low, wrGrant stays 0. It becomes 1 in the cycle in which a high-to-low transition of ceN or weN is seen, and stays 1 while both remain low.
- R4: A swStoreReq or an external busy-line fall that arrives while vccLow or capLow is 1 starts no STORE.
- R5: After a start is accepted in cycle t, busyPullDown is 1 for exactly PULSE_US microseconds of clock cycles, starting at t+1. storeStart is a single-cycle pulse in cycle t+SETTLE_CYC, and only when the synchronised busy line reads low there.
- R6: If the synchronised busy line still reads high at the settle point, storeStart never pulses. busyPullDown drops in the next cycle and storeStatus becomes 2 (aborted).
- R7: With autoInhibit at 0, a 0-to-1 change of vccLow starts a STORE. A vccLow level held high does not start a second one.
- R8: With autoInhibit at 1, a rise of vccLow starts nothing, while swStoreReq still starts a STORE.
- R9: A low level driven onto the busy line by another agent, while the controller is idle, starts a STORE. It is accepted two cycles after the line falls, as seen by the synchronizer.
- R10: Store requests of any kind that arrive while a STORE is in progress are ignored and cause no second STORE.
- R11: The completion of a STORE and a recallDone pulse each withdraw the write permission. When either coincides with a falling enable edge, the withdrawal wins: no grant in that cycle, nor afterwards, until a later falling edge.
- R12: storeStatus encodes 0 idle, 1 storing, 2 aborted. The aborted value holds until the next STORE is accepted.
- R13: wrGrant is 0 while storeStatus is 1 (storing).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| vccLow | input | 1 | Main supply below switch threshold |
| capLow | input | 1 | Backup capacitor below switch threshold |
| autoInhibit | input | 1 | 1 disables supply-triggered STOREs |
| ceN | input | 1 | Chip enable, active low |
| weN | input | 1 | Write enable, active low |
| swStoreReq | input | 1 | Store request from the software unlock decoder |
| recallDone | input | 1 | One-cycle pulse when a recall completes |
| busySense | input | 1 | Sensed level of the open-drain busy line |
| wrGrant | output | 1 | Write permission to the array |
| storeStart | output | 1 | One-cycle pulse starting the nonvolatile copy |
| busyPullDown | output | 1 | Enables the pull-down on the busy line |
| storeStatus | output | 2 | 0 idle, 1 storing, 2 aborted |

## Verification
The withdrawal of write permission and the re-arming of it by an enable edge can fall in the same cycle. The bench provokes this by driving ceN and weN low in the very cycle that recallDone pulses, and by dropping the enables during a STORE window so that the edge lands before the completion. It then expects wrGrant to stay 0 in that cycle and in the next, and to rise only after a later edge. A second collision, a fresh store request landing inside a running window, is judged by checking that the pull-down window keeps its single length and that status returns to idle afterwards.

// File: rtl/nvsg_pkg.sv
package nvsg_pkg;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_STORING = 2'd1,
    ST_ABORTED = 2'd2
  } storeStatusT;

  typedef struct packed {
    logic cntClr;
    logic armClr;
    logic abortSet;
    logic abortClr;
  } ctrlStrobeT;

endpackage

// File: rtl/nvsg_dp.sv
module nvsg_dp
  import nvsg_pkg::*;
#(
  parameter int PULSE_CYC   = 1000,
  parameter int SETTLE_CYC  = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       ceN,
  input  logic       weN,
  input  logic       vccLow,
  input  logic       busySense,
  input  logic       recallDone,
  input  ctrlStrobeT stb,
  output logic       busySync,
  output logic       busyFall,
  output logic       vccRise,
  output logic       rearmOk,
  output logic       atSettle,
  output logic       atEnd,
  output logic       abortFlag
);

  localparam int CNT_W = $clog2(PULSE_CYC + 1);
  localparam logic [CNT_W-1:0] SETTLE_AT = CNT_W'(SETTLE_CYC - 1);
  localparam logic [CNT_W-1:0] END_AT    = CNT_W'(PULSE_CYC - 1);

  logic ceQ, weQ, vccQ, busyPrev, armed;
  logic edgeFall, armClear;
  logic [CNT_W-1:0] cnt;

  // busy line synchronizer, depth chosen by parameter
  generate
    if (SYNC_STAGES <= 1) begin : g_sync1
      logic syncQ;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncQ <= 1'b1;
        else       syncQ <= busySense;
      end
      assign busySync = syncQ;
    end else begin : g_syncN
      logic [SYNC_STAGES-1:0] syncQ;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncQ <= '1;
        else       syncQ <= {syncQ[SYNC_STAGES-2:0], busySense};
      end
      assign busySync = syncQ[SYNC_STAGES-1];
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ceQ      <= 1'b0;
      weQ      <= 1'b0;
      vccQ     <= 1'b1;
      busyPrev <= 1'b1;
    end else begin
      ceQ      <= ceN;
      weQ      <= weN;
      vccQ     <= vccLow;
      busyPrev <= busySync;
    end
  end

  assign edgeFall = (ceQ & ~ceN) | (weQ & ~weN);
  assign vccRise  = vccLow & ~vccQ;
  assign busyFall = busyPrev & ~busySync;
  assign armClear = stb.armClr | recallDone;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         armed <= 1'b0;
    else if (armClear) armed <= 1'b0;
    else if (edgeFall) armed <= 1'b1;
  end

  assign rearmOk = ~armClear & (armed | edgeFall);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              cnt <= '0;
    else if (stb.cntClr)    cnt <= '0;
    else if (cnt != '1)     cnt <= cnt + 1'b1;
  end

  assign atSettle = (cnt == SETTLE_AT);
  assign atEnd    = (cnt == END_AT);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             abortFlag <= 1'b0;
    else if (stb.abortSet) abortFlag <= 1'b1;
    else if (stb.abortClr) abortFlag <= 1'b0;
  end

  // R11: a clear request always leaves the arm flag low next cycle
  a_r11_clear_wins: assert property (@(posedge clk) disable iff (!rstN)
    armClear |=> !armed);

  // R12: an abort marks the status flag in the following cycle
  a_r12_abort_sticks: assert property (@(posedge clk) disable iff (!rstN)
    stb.abortSet |=> abortFlag);

endmodule

// File: rtl/nvsg_ctrl.sv
module nvsg_ctrl
  import nvsg_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       swStoreReq,
  input  logic       autoInhibit,
  input  logic       vccLow,
  input  logic       capLow,
  input  logic       vccRise,
  input  logic       busyFall,
  input  logic       busySync,
  input  logic       atSettle,
  input  logic       atEnd,
  output logic       busyPullDown,
  output logic       storeStart,
  output logic       storing,
  output ctrlStrobeT stb
);

  typedef enum logic [1:0] {PH_IDLE, PH_PROBE, PH_HOLD} phaseT;

  phaseT phase, phaseNext;
  logic  supplyOk, autoTrig, extTrig;

  assign supplyOk = ~vccLow & ~capLow;
  assign autoTrig = vccRise & ~autoInhibit;
  assign extTrig  = (swStoreReq | busyFall) & supplyOk;

  always_comb begin
    phaseNext    = phase;
    stb          = '0;
    storeStart   = 1'b0;
    busyPullDown = 1'b0;
    unique case (phase)
      PH_IDLE: begin
        if (autoTrig || extTrig) begin
          phaseNext    = PH_PROBE;
          stb.cntClr   = 1'b1;
          stb.abortClr = 1'b1;
        end
      end
      PH_PROBE: begin
        busyPullDown = 1'b1;
        if (atSettle) begin
          if (!busySync) begin
            storeStart = 1'b1;
            phaseNext  = PH_HOLD;
          end else begin
            stb.abortSet = 1'b1;
            phaseNext    = PH_IDLE;
          end
        end
      end
      PH_HOLD: begin
        busyPullDown = 1'b1;
        if (atEnd) begin
          stb.armClr = 1'b1;
          phaseNext  = PH_IDLE;
        end
      end
      default: phaseNext = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) phase <= PH_IDLE;
    else       phase <= phaseNext;
  end

  assign storing = (phase != PH_IDLE);

  // R5: the start pulse only occurs while the line is being pulled
  a_r5_start_with_pull: assert property (@(posedge clk) disable iff (!rstN)
    storeStart |-> busyPullDown);

  // R5: the start pulse never repeats on consecutive cycles
  a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    storeStart |=> !storeStart);

  // R6: abandoning a store releases the line at once
  a_r6_abort_release: assert property (@(posedge clk) disable iff (!rstN)
    stb.abortSet |=> !busyPullDown);

  // R10: once started, a window is not restarted by new requests
  a_r10_no_restart: assert property (@(posedge clk) disable iff (!rstN)
    storing |-> !stb.cntClr);

endmodule

// File: rtl/nvStoreGuard.sv
module nvStoreGuard
  import nvsg_pkg::*;
#(
  parameter int CLK_HZ      = 50_000_000,
  parameter int PULSE_US    = 20,
  parameter int SETTLE_CYC  = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       vccLow,
  input  logic       capLow,
  input  logic       autoInhibit,
  input  logic       ceN,
  input  logic       weN,
  input  logic       swStoreReq,
  input  logic       recallDone,
  input  logic       busySense,
  output logic       wrGrant,
  output logic       storeStart,
  output logic       busyPullDown,
  output logic [1:0] storeStatus
);

  localparam int PULSE_CYC = (CLK_HZ / 1_000_000) * PULSE_US;

  ctrlStrobeT stb;
  logic busySync, busyFall, vccRise, rearmOk, atSettle, atEnd, abortFlag;
  logic storing;
  storeStatusT statusNow;

  nvsg_dp #(
    .PULSE_CYC  (PULSE_CYC),
    .SETTLE_CYC (SETTLE_CYC),
    .SYNC_STAGES(SYNC_STAGES)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .ceN       (ceN),
    .weN       (weN),
    .vccLow    (vccLow),
    .busySense (busySense),
    .recallDone(recallDone),
    .stb       (stb),
    .busySync  (busySync),
    .busyFall  (busyFall),
    .vccRise   (vccRise),
    .rearmOk   (rearmOk),
    .atSettle  (atSettle),
    .atEnd     (atEnd),
    .abortFlag (abortFlag)
  );

  nvsg_ctrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .swStoreReq  (swStoreReq),
    .autoInhibit (autoInhibit),
    .vccLow      (vccLow),
    .capLow      (capLow),
    .vccRise     (vccRise),
    .busyFall    (busyFall),
    .busySync    (busySync),
    .atSettle    (atSettle),
    .atEnd       (atEnd),
    .busyPullDown(busyPullDown),
    .storeStart  (storeStart),
    .storing     (storing),
    .stb         (stb)
  );

  assign wrGrant = rearmOk & ~ceN & ~weN & ~vccLow & ~capLow & ~storing;

  always_comb begin
    if (storing)        statusNow = ST_STORING;
    else if (abortFlag) statusNow = ST_ABORTED;
    else                statusNow = ST_IDLE;
  end
  assign storeStatus = statusNow;

  // R2: low supply or low capacitor never lets a write through
  a_r2_supply_blocks: assert property (@(posedge clk) disable iff (!rstN)
    (vccLow || capLow) |-> !wrGrant);

  // R13: no writes reach the array during a store
  a_r13_no_grant_storing: assert property (@(posedge clk) disable iff (!rstN)
    (storeStatus == 2'd1) |-> !wrGrant);

  // R6: aborted status shows the line released
  a_r6_aborted_idle_line: assert property (@(posedge clk) disable iff (!rstN)
    (storeStatus == 2'd2) |-> !busyPullDown);

endmodule

// File: tb/sim_nvStoreGuard.sv
module sim_nvStoreGuard;

  localparam int CLK_HZ = 1_000_000;
  localparam int PULSE  = 20;
  localparam int SETTLE = 4;

  typedef struct {
    string    tag;
    bit [3:0] mask;  // 3 grant, 2 pull, 1 start, 0 status
    bit       grant;
    bit       pull;
    bit       start;
    bit [1:0] status;
  } expT;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic vccLow = 1'b0, capLow = 1'b0, autoInhibit = 1'b0;
  logic ceN = 1'b0, weN = 1'b0, swStoreReq = 1'b0, recallDone = 1'b0;
  logic forceHi = 1'b0, extLow = 1'b0;
  logic busySense;
  logic wrGrant, storeStart, busyPullDown;
  logic [1:0] storeStatus;

  logic nxRst = 1'b0, nxVcc = 1'b0, nxCap = 1'b0, nxInh = 1'b0;
  logic nxCe = 1'b0, nxWe = 1'b0, nxSw = 1'b0, nxRec = 1'b0;
  logic nxForceHi = 1'b0, nxExtLow = 1'b0;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;
  expT expQ[$];

  always #10 clk = ~clk;

  // open-drain line: a strong external high overrides the pull-down
  assign busySense = forceHi ? 1'b1 : ((busyPullDown || extLow) ? 1'b0 : 1'b1);

  nvStoreGuard #(
    .CLK_HZ    (CLK_HZ),
    .PULSE_US  (20),
    .SETTLE_CYC(SETTLE)
  ) u0 (
    .clk         (clk),
    .rstN        (rstN),
    .vccLow      (vccLow),
    .capLow      (capLow),
    .autoInhibit (autoInhibit),
    .ceN         (ceN),
    .weN         (weN),
    .swStoreReq  (swStoreReq),
    .recallDone  (recallDone),
    .busySense   (busySense),
    .wrGrant     (wrGrant),
    .storeStart  (storeStart),
    .busyPullDown(busyPullDown),
    .storeStatus (storeStatus)
  );

  // driver: apply staged inputs at the falling edge and queue the expectation
  task automatic tick(input string tag, input bit [3:0] m, input bit g,
                      input bit p, input bit s, input bit [1:0] st);
    expT e;
    @(negedge clk);
    rstN = nxRst; vccLow = nxVcc; capLow = nxCap; autoInhibit = nxInh;
    ceN = nxCe; weN = nxWe; swStoreReq = nxSw; recallDone = nxRec;
    forceHi = nxForceHi; extLow = nxExtLow;
    e.tag = tag; e.mask = m; e.grant = g; e.pull = p; e.start = s; e.status = st;
    expQ.push_back(e);
  endtask

  // monitor: compare shortly after the driver, well away from the rising edge
  always @(negedge clk) begin
    #2;
    if (expQ.size() > 0) begin
      expT e;
      bit bad;
      e = expQ.pop_front();
      if (e.mask != 4'b0) begin
        bad = 1'b0;
        if (e.mask[3] && wrGrant !== e.grant) bad = 1'b1;
        if (e.mask[2] && busyPullDown !== e.pull) bad = 1'b1;
        if (e.mask[1] && storeStart !== e.start) bad = 1'b1;
        if (e.mask[0] && storeStatus !== e.status) bad = 1'b1;
        checks++;
        if (bad) begin
          failures++;
          $display("FAIL %s grant=%0b/%0b pull=%0b/%0b start=%0b/%0b status=%0d/%0d (actual/expected)",
                   e.tag, wrGrant, e.grant, busyPullDown, e.pull, storeStart, e.start,
                   storeStatus, e.status);
        end
      end
    end
  end

  // one full pull-down window, j counts cycles after acceptance
  task automatic window(input string tag, input bit inject);
    for (int j = 0; j < PULSE; j++) begin
      nxSw = (inject && j == 5);
      if (inject && j == 6) begin nxCe = 1'b0; nxWe = 1'b0; end
      nxExtLow = 1'b0;
      tick(tag, (inject && j >= 6) ? 4'b1111 : 4'b0111, 1'b0, 1'b1,
           (j == SETTLE - 1), 2'd1);
    end
    nxSw = 1'b0;
  endtask

  initial begin
    // R1 reset state, enables already low at power-up
    tick("R1 reset", 4'b1111, 0, 0, 0, 2'd0);
    tick("R1 reset", 4'b1111, 0, 0, 0, 2'd0);
    nxRst = 1'b1;
    // R3 no grant without a fresh edge
    tick("R3 held low after reset", 4'b1000, 0, 0, 0, 2'd0);
    tick("R3 held low after reset", 4'b1000, 0, 0, 0, 2'd0);
    nxWe = 1'b1;
    tick("R3 we high", 4'b1000, 0, 0, 0, 2'd0);
    nxWe = 1'b0;
    tick("R3 we falls", 4'b1000, 1, 0, 0, 2'd0);
    tick("R3 stays armed", 4'b1000, 1, 0, 0, 2'd0);
    // R2 capacitor flag blocks writes
    nxCap = 1'b1;
    tick("R2 cap low", 4'b1000, 0, 0, 0, 2'd0);
    // R4 software request under low supply is refused
    nxSw = 1'b1;
    tick("R4 sw under low cap", 4'b1111, 0, 0, 0, 2'd0);
    nxSw = 1'b0; nxCap = 1'b0;
    tick("R4 no store started", 4'b1111, 1, 0, 0, 2'd0);
    tick("R4 no store started", 4'b0101, 0, 0, 0, 2'd0);
    nxCe = 1'b1; nxWe = 1'b1;
    tick("idle", 4'b1000, 0, 0, 0, 2'd0);

    // R5 software store, with R10 request and R13 write attempt inside
    nxSw = 1'b1;
    tick("R5 accept", 4'b0111, 0, 0, 0, 2'd0);
    window("R5 R10 R13 window", 1'b1);
    tick("R11 completion clears arm", 4'b1111, 0, 0, 0, 2'd0);
    tick("R10 no second store", 4'b1111, 0, 0, 0, 2'd0);
    nxCe = 1'b1;
    tick("R11 ce high", 4'b1000, 0, 0, 0, 2'd0);
    nxCe = 1'b0;
    tick("R11 rearm after new edge", 4'b1000, 1, 0, 0, 2'd0);
    nxCe = 1'b1; nxWe = 1'b1;
    tick("idle", 4'b0111, 0, 0, 0, 2'd0);

    // R6 line held high externally: abort
    nxForceHi = 1'b1; nxSw = 1'b1;
    tick("R6 accept", 4'b0111, 0, 0, 0, 2'd0);
    nxSw = 1'b0;
    for (int j = 0; j < SETTLE; j++)
      tick("R6 probing", 4'b0111, 0, 1, 0, 2'd1);
    tick("R6 aborted", 4'b0111, 0, 0, 0, 2'd2);
    nxForceHi = 1'b0;
    tick("R12 aborted holds", 4'b0111, 0, 0, 0, 2'd2);
    tick("R12 aborted holds", 4'b0111, 0, 0, 0, 2'd2);

    // R7 automatic store on supply falling through threshold
    nxVcc = 1'b1;
    tick("R7 vcc crosses", 4'b0111, 0, 0, 0, 2'd2);
    window("R7 R12 auto window", 1'b0);
    tick("R7 no retrigger on level", 4'b0111, 0, 0, 0, 2'd0);
    tick("R7 no retrigger on level", 4'b0111, 0, 0, 0, 2'd0);
    nxVcc = 1'b0;
    tick("idle", 4'b0111, 0, 0, 0, 2'd0);

    // R8 inhibit mode
    nxInh = 1'b1; nxVcc = 1'b1;
    tick("R8 vcc crosses inhibited", 4'b0111, 0, 0, 0, 2'd0);
    tick("R8 no auto store", 4'b0111, 0, 0, 0, 2'd0);
    nxVcc = 1'b0;
    tick("R8 no auto store", 4'b0111, 0, 0, 0, 2'd0);
    nxSw = 1'b1;
    tick("R8 sw accept", 4'b0111, 0, 0, 0, 2'd0);
    window("R8 sw window inhibited", 1'b0);
    tick("R8 done", 4'b0111, 0, 0, 0, 2'd0);
    nxInh = 1'b0;
    tick("idle", 4'b0111, 0, 0, 0, 2'd0);
    tick("idle", 4'b0111, 0, 0, 0, 2'd0);

    // R9 external agent pulls the line low
    nxExtLow = 1'b1;
    tick("R9 line falls", 4'b0111, 0, 0, 0, 2'd0);
    tick("R9 sync stage", 4'b0111, 0, 0, 0, 2'd0);
    tick("R9 accept", 4'b0111, 0, 0, 0, 2'd0);
    window("R9 external window", 1'b0);
    tick("R9 done", 4'b0111, 0, 0, 0, 2'd0);
    tick("R9 done", 4'b0111, 0, 0, 0, 2'd0);
    tick("R9 done", 4'b0111, 0, 0, 0, 2'd0);

    // R11 recall clear coinciding with an enable falling edge
    nxCe = 1'b0; nxWe = 1'b0; nxRec = 1'b1;
    tick("R11 recall vs edge", 4'b1111, 0, 0, 0, 2'd0);
    nxRec = 1'b0;
    tick("R11 stays blocked", 4'b1000, 0, 0, 0, 2'd0);
    nxWe = 1'b1;
    tick("R11 we high", 4'b1000, 0, 0, 0, 2'd0);
    nxWe = 1'b0;
    tick("R11 rearmed", 4'b1000, 1, 0, 0, 2'd0);
    nxVcc = 1'b1; nxInh = 1'b1;
    tick("R2 vcc low blocks", 4'b1000, 0, 0, 0, 2'd0);
    nxVcc = 1'b0;
    tick("R2 vcc back", 4'b1000, 1, 0, 0, 2'd0);

    tick("drain", 4'b0000, 0, 0, 0, 2'd0);
    tick("drain", 4'b0000, 0, 0, 0, 2'd0);
    @(negedge clk);
    #5;
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #(20 * 200000);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule